// File: doc/BRIEF.md
# Serial NOR Flash Device Model

A synthesizable model of a small serial NOR flash that sits on a four-wire SPI bus in mode 0. A host selects it by pulling the chip-select low, clocks in an opcode and an address, and then either reads data back or gives bytes to be written. The model runs in its own system clock domain. It samples the SPI pins through two-stage synchronisers, so the system clock must run at least eight times faster than SCK.

The storage array is built from 256-byte pages, and sixteen pages make a 4 KB sector. The default build has one sector, so simulation stays small. A second bank holds three 256-byte security registers whose contents are computed from a seed, so this bank needs no storage. The model decodes six opcodes. Identification read is 0x9F. Array read is 0x03. Security read is 0x48. Write enable is 0x06. Page program is 0x02. Sector erase is 0x20. Programming follows NOR rules: a bit can only go from 1 to 0, and erase brings every byte back to 0xFF.

The controller is one state machine with these states:
- ST_IDLE waits for select.
- ST_OPCODE takes the first byte.
- ST_ADDR collects three address bytes.
- ST_DUMMY absorbs eight clocks.
- ST_STREAM shifts out data.
- ST_FILL stages page data.
- ST_HOLD discards bytes until deselect.
- ST_PROGRAM and ST_ERASE are the commit loops.

The transitions are as follows:
- IDLE→OPCODE happens on select.
- OPCODE→STREAM happens for 0x9F.
- OPCODE→ADDR happens for 0x03, 0x48, 0x02 and 0x20.
- OPCODE→HOLD happens for any other byte.
- ADDR→STREAM, ADDR→DUMMY, ADDR→FILL or ADDR→HOLD happens after the third address byte, depending on the opcode.
- DUMMY→STREAM happens after the dummy byte.
- FILL→PROGRAM and HOLD→ERASE happen on a clean deselect when the latch is set.
- Every other deselect leads to IDLE.
- PROGRAM→IDLE and ERASE→IDLE happen when the loop index reaches its last value.

Top module: `snor_flash`

## Requirements
- R1: While cs_n is high, miso is held at 0. After reset, miso is 0 and the write-enable latch is clear.
- R2: Opcode 0x9F returns the 24-bit identification parameter (default 0xC2260C) as three bytes, most significant byte first. Any further bytes read as 0x00.
- R3: Opcode 0x03 takes a 24-bit address, most significant byte first. It then streams bytes from consecutive addresses while cs_n stays low. The address is taken modulo the array size, so a read past the last byte continues from byte 0.
- R4: Opcode 0x48 takes a 24-bit address, then one dummy byte (eight clocks), then streams data. Address bits 15:12 select register n. For n = 1, 2 or 3, the byte at offset k (address bits 7:0) is ((n*0x3B) XOR (k*0x5D) XOR 0xA7) mod 256. Any other n reads as 0xFF. The offset wraps within the register's 256 bytes.
- R5: Opcode 0x06, ended on a byte boundary, sets the write-enable latch. When the latch is clear, page program and sector erase leave the array unchanged.
- R6: Page program (0x02) stages 1 to 256 or more data bytes at page offsets that start at address bits 7:0 and wrap within the page. A later byte at the same offset replaces an earlier one. Each staged byte is written as old AND data, and untouched bytes keep their value.
- R7: Sector erase (0x20) sets all 4096 bytes of the sector that contains the address to 0xFF. It takes one system clock per byte, and select activity during that time is ignored.
- R8: The write-enable latch clears when a program or erase finishes.
- R9: A command executes only if cs_n rises after a whole number of bytes. If cs_n rises mid-byte, nothing happens, and both the array and the latch are left unchanged.
- R10: The model samples mosi on rising SCK edges and changes miso after falling SCK edges, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 while deselected |

## Verification
A miso bit changes about three system clocks after the falling SCK edge: two synchroniser stages, then the output register. The bench therefore holds each SCK phase for eight system clocks and samples miso at the end of the low phase. A program commit starts about three clocks after cs_n rises and runs for 256 clocks, and an erase runs for 4096 clocks. The bench waits a fixed margin beyond each of these before it issues another command. Expected data comes from an array model in the bench, which applies the AND-only program rule, page wrap, last-write-wins, erase and latch gating, and from the security formula computed arithmetically.

// File: rtl/snor_pkg.sv
package snor_pkg;
    localparam logic [7:0] OP_IDENT = 8'h9F;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_SECRD = 8'h48;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h20;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY, ST_STREAM,
        ST_FILL, ST_HOLD, ST_PROGRAM, ST_ERASE
    } state_e;
endpackage

// File: rtl/snor_spi_if.sv
// Pin synchroniser and byte serialiser (SPI mode 0, MSB first).
module snor_spi_if (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       cs_start,
    output logic       cs_end,
    output logic       whole,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       miso
);
    logic [2:0] sck_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic [2:0] bitcnt;
    logic [6:0] in_sh;
    logic [7:0] tx_sh;
    logic       sck_rise, sck_fall, cs_act;

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign sck_fall = ~sck_s[1] & sck_s[2];
    assign cs_act   = ~cs_s[1];
    assign cs_start = ~cs_s[1] & cs_s[2];
    assign cs_end   = cs_s[1] & ~cs_s[2];
    assign whole    = (bitcnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= 3'b000;
            cs_s   <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sck_s  <= {sck_s[1:0], sck};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= 3'd0;
            in_sh    <= 7'd0;
            tx_sh    <= 8'd0;
            rx_valid <= 1'b0;
            rx_byte  <= 8'd0;
            miso     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!cs_act) begin
                bitcnt <= 3'd0;
                tx_sh  <= 8'd0;
                miso   <= 1'b0;
            end else begin
                if (sck_rise) begin
                    in_sh  <= {in_sh[5:0], mosi_s[1]};
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {in_sh, mosi_s[1]};
                    end
                end
                if (sck_fall) begin
                    if (bitcnt == 3'd0) begin
                        miso  <= tx_byte[7];
                        tx_sh <= {tx_byte[6:0], 1'b0};
                    end else begin
                        miso  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/snor_store.sv
// Main array (one write port, combinational read) and computed security bank.
module snor_store #(
    parameter int          ARRAY_BYTES = 4096,
    parameter int          AW          = 12,
    parameter logic [7:0]  SEC_SEED    = 8'hA7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic [3:0]    sec_sel,
    input  logic [7:0]    sec_off,
    output logic [7:0]    sec_data
);
    logic [7:0] cells [ARRAY_BYTES];
    logic [7:0] sel_term, off_term;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

    always_comb begin
        sel_term = {4'd0, sec_sel} * 8'h3B;
        off_term = sec_off * 8'h5D;
        if (sec_sel >= 4'd1 && sec_sel <= 4'd3)
            sec_data = sel_term ^ off_term ^ SEC_SEED;
        else
            sec_data = 8'hFF;
    end
endmodule

// File: rtl/snor_ctrl.sv
// Command state machine, page staging buffer and commit loops.
module snor_ctrl
    import snor_pkg::*;
#(
    parameter int          PAGE_BYTES   = 256,
    parameter int          SECTOR_BYTES = 4096,
    parameter int          AW           = 12,
    parameter logic [23:0] IDENT        = 24'hC2260C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_start,
    input  logic          cs_end,
    input  logic          whole,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    mem_rdata,
    input  logic [7:0]    sec_data,
    output logic [7:0]    tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic [3:0]    sec_sel,
    output logic [7:0]    sec_off,
    output state_e        st,
    output logic          wel
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int SW = $clog2(SECTOR_BYTES);
    localparam logic [SW-1:0] LAST_P = SW'(PAGE_BYTES - 1);
    localparam logic [SW-1:0] LAST_S = SW'(SECTOR_BYTES - 1);
    localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] SECT_MASK = AW'(SECTOR_BYTES - 1);

    state_e               st_nx, after_byte;
    logic [7:0]           cmd;
    logic [23:0]          addr;
    logic [1:0]           acnt;
    logic [SW-1:0]        idx;
    logic [PAGE_BYTES-1:0] pval;
    logic [7:0]           pbuf [PAGE_BYTES];
    logic [PW-1:0]        poff, cidx;
    logic [AW-1:0]        page_base, sect_base;
    logic                 do_prog, do_erase;

    assign poff      = addr[PW-1:0];
    assign cidx      = idx[PW-1:0];
    assign page_base = addr[AW-1:0] & ~PAGE_MASK;
    assign sect_base = addr[AW-1:0] & ~SECT_MASK;
    assign do_prog   = whole && wel && (st == ST_FILL) && (|pval);
    assign do_erase  = whole && wel && (st == ST_HOLD) && (cmd == OP_ERASE);

    // Successor after a received byte
    always_comb begin
        after_byte = st;
        if (st == ST_OPCODE) begin
            case (rx_byte)
                OP_IDENT:                             after_byte = ST_STREAM;
                OP_READ, OP_SECRD, OP_PROG, OP_ERASE: after_byte = ST_ADDR;
                default:                              after_byte = ST_HOLD;
            endcase
        end else if (st == ST_ADDR && acnt == 2'd2) begin
            case (cmd)
                OP_READ:  after_byte = ST_STREAM;
                OP_SECRD: after_byte = ST_DUMMY;
                OP_PROG:  after_byte = ST_FILL;
                default:  after_byte = ST_HOLD;
            endcase
        end else if (st == ST_DUMMY) begin
            after_byte = ST_STREAM;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (cs_start) st_nx = ST_OPCODE;
            ST_OPCODE, ST_ADDR, ST_DUMMY, ST_STREAM, ST_FILL, ST_HOLD: begin
                if (cs_end)
                    st_nx = do_prog ? ST_PROGRAM : (do_erase ? ST_ERASE : ST_IDLE);
                else if (rx_valid)
                    st_nx = after_byte;
            end
            ST_PROGRAM: if (idx == LAST_P) st_nx = ST_IDLE;
            ST_ERASE:   if (idx == LAST_S) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd  <= 8'd0;
            addr <= 24'd0;
            acnt <= 2'd0;
            wel  <= 1'b0;
            pval <= '0;
            idx  <= '0;
        end else begin
            if (st == ST_OPCODE && rx_valid) begin
                cmd  <= rx_byte;
                addr <= 24'd0;
                acnt <= 2'd0;
                pval <= '0;
            end
            if (st == ST_ADDR && rx_valid) begin
                addr <= {addr[15:0], rx_byte};
                acnt <= acnt + 2'd1;
            end
            if (st == ST_STREAM && rx_valid) begin
                if (cmd == OP_SECRD) addr[7:0] <= addr[7:0] + 8'd1;
                else                 addr      <= addr + 24'd1;
            end
            if (st == ST_FILL && rx_valid) begin
                pval[poff]       <= 1'b1;
                addr[PW-1:0]     <= poff + 1'b1;
            end
            if (cs_end && whole && st == ST_HOLD && cmd == OP_WREN)
                wel <= 1'b1;
            if ((st == ST_PROGRAM || st == ST_ERASE) && st_nx == ST_IDLE)
                wel <= 1'b0;
            if (st == ST_PROGRAM || st == ST_ERASE) idx <= idx + 1'b1;
            else                                    idx <= '0;
        end
    end

    // Page staging storage
    always_ff @(posedge clk) begin
        if (st == ST_FILL && rx_valid) pbuf[poff] <= rx_byte;
    end

    // Outputs
    always_comb begin
        mem_raddr = (st == ST_PROGRAM) ? (page_base | AW'(cidx)) : addr[AW-1:0];
        mem_we    = (st == ST_ERASE) || (st == ST_PROGRAM && pval[cidx]);
        mem_waddr = (st == ST_ERASE) ? (sect_base | AW'(idx)) : (page_base | AW'(cidx));
        mem_wdata = (st == ST_ERASE) ? 8'hFF : (mem_rdata & pbuf[cidx]);
        sec_sel   = addr[15:12];
        sec_off   = addr[7:0];
        case (cmd)
            OP_IDENT: begin
                if (addr[23:2] != 22'd0)   tx_byte = 8'h00;
                else if (addr[1:0] == 2'd0) tx_byte = IDENT[23:16];
                else if (addr[1:0] == 2'd1) tx_byte = IDENT[15:8];
                else if (addr[1:0] == 2'd2) tx_byte = IDENT[7:0];
                else                        tx_byte = 8'h00;
            end
            OP_READ:  tx_byte = mem_rdata;
            OP_SECRD: tx_byte = sec_data;
            default:  tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/snor_flash.sv
module snor_flash #(
    parameter int          SECTORS          = 1,
    parameter int          PAGES_PER_SECTOR = 16,
    parameter int          PAGE_BYTES       = 256,
    parameter logic [23:0] IDENT            = 24'hC2260C,
    parameter logic [7:0]  SEC_SEED         = 8'hA7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    localparam int SECTOR_BYTES = PAGES_PER_SECTOR * PAGE_BYTES;
    localparam int ARRAY_BYTES  = SECTORS * SECTOR_BYTES;
    localparam int AW           = $clog2(ARRAY_BYTES);

    logic          cs_start, cs_end, whole, rx_valid;
    logic [7:0]    rx_byte, tx_byte;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [7:0]    mem_wdata, mem_rdata, sec_data, sec_off;
    logic [3:0]    sec_sel;
    snor_pkg::state_e st_w;
    logic          wel_w;

    snor_spi_if u_spi (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(tx_byte), .cs_start(cs_start), .cs_end(cs_end), .whole(whole),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(miso)
    );

    snor_ctrl #(
        .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .AW(AW), .IDENT(IDENT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .cs_end(cs_end),
        .whole(whole), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mem_rdata(mem_rdata), .sec_data(sec_data), .tx_byte(tx_byte),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .sec_sel(sec_sel), .sec_off(sec_off),
        .st(st_w), .wel(wel_w)
    );

    snor_store #(
        .ARRAY_BYTES(ARRAY_BYTES), .AW(AW), .SEC_SEED(SEC_SEED)
    ) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata),
        .sec_sel(sec_sel), .sec_off(sec_off), .sec_data(sec_data)
    );
endmodule

// File: rtl/snor_flash_chk.sv
module snor_flash_chk
    import snor_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       miso,
    input state_e     st,
    input logic       wel,
    input logic       mem_we,
    input logic [7:0] mem_wdata,
    input logic [7:0] mem_rdata,
    input logic       cs_end,
    input logic       whole
);
    logic [1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt <= 2'd0;
        else if (!cs_n)        hi_cnt <= 2'd0;
        else if (hi_cnt != 2'd3) hi_cnt <= hi_cnt + 2'd1;
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == 2'd3) |-> !miso);

    // R8
    latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ($past(st) == ST_PROGRAM || $past(st) == ST_ERASE)) |-> !wel);

    // R5
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROGRAM || st == ST_ERASE) && $past(st) != st) |-> $past(wel));

    // R6
    and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && st == ST_PROGRAM) |-> ((mem_wdata & ~mem_rdata) == 8'h00));

    // R7
    erase_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |-> (mem_we && mem_wdata == 8'hFF));

    // R9
    partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_end && !whole && st != ST_PROGRAM && st != ST_ERASE)
        |=> (st == ST_IDLE && wel == $past(wel)));
endmodule

bind snor_flash snor_flash_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .st(st_w), .wel(wel_w),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cs_end(cs_end), .whole(whole)
);

// File: tb/tb_snor_flash.sv
`timescale 1ns/1ps
module tb_snor_flash;
    localparam int HP = 8;
    localparam int NB = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] model [NB];
    logic [7:0] dat   [300];
    logic [7:0] rbuf  [300];

    always #2 clk = ~clk;

    snor_flash dut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r);
        sck = 1'b0; mosi = b;
        tick(HP);
        r = miso;
        sck = 1'b1;
        tick(HP);
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) sbit(o[b], i[b]);
    endtask

    task automatic sel();
        cs_n = 1'b0; tick(HP);
    endtask

    task automatic desel();
        tick(HP); sck = 1'b0; tick(HP);
        cs_n = 1'b1; tick(HP + 4);
    endtask

    task automatic send_addr(input int a);
        logic [7:0] d;
        xfer(8'((a >> 16) & 255), d);
        xfer(8'((a >> 8) & 255), d);
        xfer(8'(a & 255), d);
    endtask

    task automatic wren();
        logic [7:0] d;
        sel(); xfer(8'h06, d); desel();
    endtask

    task automatic erase(input int a, input bit exec);
        logic [7:0] d;
        sel(); xfer(8'h20, d); send_addr(a); desel();
        tick(NB + 20);
        if (exec) begin
            int base = a & ~(NB - 1) & (NB - 1);
            for (int i = 0; i < NB; i++) model[(base + i) % NB] = 8'hFF;
        end
    endtask

    task automatic prog(input int a, input int n, input bit exec);
        logic [7:0] d;
        logic [7:0] stage [256];
        bit         used  [256];
        sel(); xfer(8'h02, d); send_addr(a);
        for (int i = 0; i < n; i++) xfer(dat[i], d);
        desel();
        tick(256 + 20);
        if (exec) begin
            for (int i = 0; i < 256; i++) used[i] = 1'b0;
            for (int i = 0; i < n; i++) begin
                stage[(a + i) & 255] = dat[i];
                used[(a + i) & 255]  = 1'b1;
            end
            for (int i = 0; i < 256; i++)
                if (used[i]) model[((a & ~255) + i) % NB] = model[((a & ~255) + i) % NB] & stage[i];
        end
    endtask

    task automatic rd(input int a, input int n);
        logic [7:0] d;
        sel(); xfer(8'h03, d); send_addr(a);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        desel();
    endtask

    task automatic rd_chk(input string tag, input int a, input int n);
        rd(a, n);
        for (int i = 0; i < n; i++) chk(tag, 32'(rbuf[i]), 32'(model[(a + i) % NB]));
    endtask

    function automatic logic [7:0] sec_exp(input int sel_n, input int off);
        if (sel_n >= 1 && sel_n <= 3) return 8'(((sel_n * 59) ^ (off * 93) ^ 8'hA7) & 255);
        return 8'hFF;
    endfunction

    task automatic sec_chk(input int a, input int n);
        logic [7:0] d;
        sel(); xfer(8'h48, d); send_addr(a); xfer(8'h00, d);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        desel();
        for (int i = 0; i < n; i++)
            chk("R4 security read", 32'(rbuf[i]), 32'(sec_exp((a >> 12) & 15, (a + i) & 255)));
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] d;
        logic       r;
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(5);
        chk("R1 miso low after reset", 32'(miso), 32'd0);

        // R2 / R10: identification stream
        sel();
        xfer(8'h9F, d);
        xfer(8'h00, rbuf[0]); xfer(8'h00, rbuf[1]);
        xfer(8'h00, rbuf[2]); xfer(8'h00, rbuf[3]);
        desel();
        chk("R2 ident byte0", 32'(rbuf[0]), 32'hC2);
        chk("R2 ident byte1", 32'(rbuf[1]), 32'h26);
        chk("R10 ident byte2", 32'(rbuf[2]), 32'h0C);
        chk("R2 ident tail", 32'(rbuf[3]), 32'h00);
        chk("R1 miso low deselected", 32'(miso), 32'd0);

        // R7: erase, read across array end (R3 wrap)
        wren();
        erase(32'h000A55, 1'b1);
        rd_chk("R7 erased, R3 wrap", 32'h000FF8, 16);

        // R5: program with latch clear is ignored
        for (int i = 0; i < 8; i++) dat[i] = 8'h00;
        prog(32'h000200, 8, 1'b0);
        rd_chk("R5 no latch program ignored", 32'h000200, 8);

        // R6: 20 bytes from offset F0 wrap within page 2
        for (int i = 0; i < 20; i++) dat[i] = 8'((i * 37 + 5) & 255);
        wren();
        prog(32'h0002F0, 20, 1'b1);
        rd_chk("R6 page wrap", 32'h000200, 256);

        // R8: latch cleared after program
        for (int i = 0; i < 4; i++) dat[i] = 8'h00;
        prog(32'h0002F0, 4, 1'b0);
        rd_chk("R8 latch cleared", 32'h0002F0, 4);

        // R6: 258 bytes, last write wins
        for (int i = 0; i < 258; i++) dat[i] = 8'((i * 11 + 3) & 255);
        wren();
        prog(32'h000300, 258, 1'b1);
        rd_chk("R6 last write wins", 32'h000300, 4);
        rd_chk("R6 page tail", 32'h0003FE, 2);
        rd_chk("R3 page crossing", 32'h0002FC, 8);

        // R6: AND with existing contents
        for (int i = 0; i < 4; i++) dat[i] = 8'h0F;
        wren();
        prog(32'h0002F0, 4, 1'b1);
        rd_chk("R6 and rule", 32'h0002F0, 4);

        // R9: partial final byte cancels program, latch stays
        wren();
        sel(); xfer(8'h02, d); send_addr(32'h000400); xfer(8'h00, d);
        sbit(1'b0, r); sbit(1'b0, r); sbit(1'b0, r);
        desel();
        tick(300);
        rd_chk("R9 partial program", 32'h000400, 2);
        dat[0] = 8'h5A;
        prog(32'h000400, 1, 1'b1);
        rd_chk("R9 latch kept", 32'h000400, 2);

        // R9: partial write-enable does not set latch
        sel(); sbit(1'b0, r); sbit(1'b0, r); sbit(1'b0, r); sbit(1'b0, r); sbit(1'b0, r); desel();
        dat[0] = 8'h00;
        prog(32'h000401, 1, 1'b0);
        rd_chk("R9 partial wren", 32'h000400, 2);

        // R4: security registers with offset wrap and invalid selects
        sec_chk(32'h0010FC, 8);
        sec_chk(32'h0020FC, 8);
        sec_chk(32'h003010, 4);
        sec_chk(32'h000010, 4);
        sec_chk(32'h004000, 2);

        // R7 / R8: erase restores FF, latch cleared after erase
        wren();
        erase(32'h000123, 1'b1);
        rd_chk("R7 erase again", 32'h0002F0, 24);
        dat[0] = 8'h00;
        prog(32'h000500, 1, 1'b0);
        rd_chk("R8 latch cleared by erase", 32'h000500, 1);
        erase(32'h000000, 1'b0);
        rd_chk("R5 erase without latch", 32'h000500, 1);

        report();
    end
endmodule